// File: doc/BRIEF.md
# Boot-Remap Address Decoder

This block sits between a processor's 32-bit address bus and the memories and peripherals behind it. For each accepted request it works out which target the address falls in and gives the byte offset inside that target. Accesses go either to a fast system-bus path (on-chip SRAM, on-chip flash and the GPIO window) or to a slow peripheral-bus path (the rest of the register space). Each path has a fixed latency, and the block reports that latency to the requester through `ready_o`. Addresses in reserved holes complete with an error flag.

The 128 kB window at address zero is a mirror. After reset it shows flash. When software clears bit 0 of an internal remap register, it shows SRAM instead. The last 2 kB of flash hold a boot page that user accesses may not reach, either directly or through the mirror. Only one access is in flight at a time. The memory arrays return read data combinationally, in the cycle the block raises `ready_o`.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset `ready_o`, `err_o` and all four select outputs are 0, and `remap_o` is 1 (flash mirrored at address zero).
- R2: With `remap_o`=1, an address in 0x00000000..0x0001FFFF selects flash with `mem_addr_o` = addr[16:0], except the boot-page offsets 0x1F800..0x1FFFF.
- R3: With `remap_o`=0, an address in 0x00000000..0x0001FFFF selects SRAM with `mem_addr_o` = addr[12:0], so the window wraps every 8 kB.
- R4: An address in 0x00040000..0x00041FFF selects SRAM with offset addr[12:0]. An address in 0x00080000..0x0009F7FF selects flash with offset addr[16:0].
- R5: The boot page (0x0009F800..0x0009FFFF, or mirror offsets 0x1F800..0x1FFFF while `remap_o`=1) is treated as reserved.
- R6: A reserved address finishes after one cycle. It raises `err_o` together with `ready_o`, drives no select and no `mem_we_o`, and a read returns 0. The select outputs are never active more than one at a time.
- R7: SRAM, flash and the GPIO window 0xFFFFF400..0xFFFFF4FF (offset addr[7:0]) raise their select and `ready_o` in the first cycle after the request is accepted. A read returns that target's read-data input.
- R8: Any other address in 0xFFFF0000..0xFFFFFFFF drives `per_sel_o` for two cycles, with offset addr[15:0]. `ready_o` comes in the second of those cycles and a read returns `per_rdata_i`.
- R9: The remap register answers at word address 0xFFFF0220 with peripheral-bus latency (two cycles) and drives no select. A write loads wdata[0] when the access completes. A read returns bit 0 with bits 31..1 zero.
- R10: A request accepted on one clock edge is taken when no access is in flight. `req_i` is ignored from that edge through the cycle in which `ready_o` is high, so a held request is taken on the next edge and is decoded with the remap value in force at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| sram_rdata_i | input | 32 | SRAM read data |
| flash_rdata_i | input | 32 | Flash read data |
| gpio_rdata_i | input | 32 | GPIO window read data |
| per_rdata_i | input | 32 | Peripheral-bus read data |
| sram_sel_o | output | 1 | SRAM select |
| flash_sel_o | output | 1 | Flash select |
| gpio_sel_o | output | 1 | GPIO window select |
| per_sel_o | output | 1 | Peripheral-bus select |
| mem_we_o | output | 1 | Write strobe to the selected target |
| mem_addr_o | output | 17 | Byte offset inside the selected target |
| mem_wdata_o | output | 32 | Write data to the selected target |
| ready_o | output | 1 | Access complete |
| err_o | output | 1 | Access hit a reserved address |
| rdata_o | output | 32 | Read data, valid with ready_o |
| remap_o | output | 1 | Remap bit: 1 = flash at zero, 0 = SRAM at zero |

## Verification
The two functions that can meet in one cycle are the completion of a remap-register write and the arrival of the next request aimed at the low window. The bench holds `req_i` high across a write that sets the remap bit and, in the same held request, switches the address to a low-window read. It then checks three things: the read is not taken while the write is completing, it is taken on the next edge, and it lands on flash under the new mapping rather than on SRAM under the old one. Random traffic that mixes remap writes with low-window and boot-page accesses repeats this pairing, and each result is compared against a bench model that tracks the remap bit.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned OFF_W   = 17;  // mirror window and flash size, 128 kB
  localparam int unsigned SRAM_AW = 13;  // 8 kB
  localparam int unsigned BOOT_AW = 11;  // 2 kB boot page at top of flash
  localparam int unsigned REG_AW  = 16;
  localparam int unsigned GPIO_AW = 8;

  localparam logic [ADDR_W-1:0] SRAM_BASE  = 32'h0004_0000;
  localparam logic [ADDR_W-1:0] FLASH_BASE = 32'h0008_0000;
  localparam logic [ADDR_W-1:0] REG_BASE   = 32'hFFFF_0000;
  localparam logic [ADDR_W-1:0] GPIO_BASE  = 32'hFFFF_F400;
  localparam logic [ADDR_W-1:0] REMAP_ADDR = 32'hFFFF_0220;

  localparam int unsigned SYS_LAT = 1;
  localparam int unsigned PER_LAT = 2;
  localparam int unsigned CNT_W   = $clog2(PER_LAT + 1);
  localparam int unsigned NSEL    = 4;

  typedef enum logic [2:0] {
    RG_RSVD, RG_SRAM, RG_FLASH, RG_GPIO, RG_PER, RG_REMAP
  } region_e;

  function automatic region_e sel_region(int unsigned idx);
    case (idx)
      0:       return RG_SRAM;
      1:       return RG_FLASH;
      2:       return RG_GPIO;
      default: return RG_PER;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lat_of(region_e r);
    if (r == RG_PER || r == RG_REMAP) return CNT_W'(PER_LAT);
    return CNT_W'(SYS_LAT);
  endfunction
endpackage

// File: rtl/brd_region_decode.sv
module brd_region_decode
  import brd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              remap_i,
  output region_e           region_o,
  output logic [OFF_W-1:0]  off_o
);
  logic in_low, in_sram, in_flash, in_reg, in_gpio, is_remap, boot_hit;

  always_comb begin
    in_low   = addr_i[ADDR_W-1:OFF_W]   == '0;
    in_sram  = addr_i[ADDR_W-1:SRAM_AW] == SRAM_BASE[ADDR_W-1:SRAM_AW];
    in_flash = addr_i[ADDR_W-1:OFF_W]   == FLASH_BASE[ADDR_W-1:OFF_W];
    in_reg   = addr_i[ADDR_W-1:REG_AW]  == REG_BASE[ADDR_W-1:REG_AW];
    in_gpio  = addr_i[ADDR_W-1:GPIO_AW] == GPIO_BASE[ADDR_W-1:GPIO_AW];
    is_remap = addr_i[ADDR_W-1:2]       == REMAP_ADDR[ADDR_W-1:2];
    boot_hit = &addr_i[OFF_W-1:BOOT_AW];

    region_o = RG_RSVD;
    off_o    = '0;
    if (in_low) begin
      if (remap_i) begin
        if (!boot_hit) begin
          region_o = RG_FLASH;
          off_o    = addr_i[OFF_W-1:0];
        end
      end else begin
        region_o = RG_SRAM;
        off_o    = OFF_W'(addr_i[SRAM_AW-1:0]);
      end
    end else if (in_sram) begin
      region_o = RG_SRAM;
      off_o    = OFF_W'(addr_i[SRAM_AW-1:0]);
    end else if (in_flash) begin
      if (!boot_hit) begin
        region_o = RG_FLASH;
        off_o    = addr_i[OFF_W-1:0];
      end
    end else if (is_remap) begin
      region_o = RG_REMAP;
      off_o    = OFF_W'(addr_i[REG_AW-1:0]);
    end else if (in_gpio) begin
      region_o = RG_GPIO;
      off_o    = OFF_W'(addr_i[GPIO_AW-1:0]);
    end else if (in_reg) begin
      region_o = RG_PER;
      off_o    = OFF_W'(addr_i[REG_AW-1:0]);
    end
  end
endmodule

// File: rtl/brd_access_timer.sv
module brd_access_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] lat_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign busy_o = cnt_q != '0;
  assign done_o = cnt_q == CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!busy_o && start_i) cnt_q <= lat_i;
    else if (busy_o)            cnt_q <= cnt_q - CW'(1);
  end

  // R10
  inflight_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/brd_remap_reg.sv
module brd_remap_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  output logic remap_o
);
  logic remap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   remap_q <= 1'b1;
    else if (wr_i) remap_q <= wbit_i;
  end

  assign remap_o = remap_q;

  // R9
  remap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(remap_q));
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import brd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] sram_rdata_i,
  input  logic [31:0] flash_rdata_i,
  input  logic [31:0] gpio_rdata_i,
  input  logic [31:0] per_rdata_i,
  output logic        sram_sel_o,
  output logic        flash_sel_o,
  output logic        gpio_sel_o,
  output logic        per_sel_o,
  output logic        mem_we_o,
  output logic [16:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        ready_o,
  output logic        err_o,
  output logic [31:0] rdata_o,
  output logic        remap_o
);
  region_e            dec_region, region_q;
  logic [OFF_W-1:0]   dec_off, off_q;
  logic               we_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               busy, done, accept, remap;
  logic [NSEL-1:0]    sel_vec;

  brd_region_decode u_dec (
    .addr_i   (addr_i),
    .remap_i  (remap),
    .region_o (dec_region),
    .off_o    (dec_off)
  );

  brd_access_timer #(.CW(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req_i),
    .lat_i   (lat_of(dec_region)),
    .busy_o  (busy),
    .done_o  (done)
  );

  brd_remap_reg u_remap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (done && we_q && region_q == RG_REMAP),
    .wbit_i  (wdata_q[0]),
    .remap_o (remap)
  );

  assign accept = req_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= RG_RSVD;
      off_q    <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
    end else if (accept) begin
      region_q <= dec_region;
      off_q    <= dec_off;
      we_q     <= we_i;
      wdata_q  <= wdata_i;
    end
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel_vec[g] = busy && (region_q == sel_region(g));
  end

  assign sram_sel_o  = sel_vec[0];
  assign flash_sel_o = sel_vec[1];
  assign gpio_sel_o  = sel_vec[2];
  assign per_sel_o   = sel_vec[3];
  assign mem_we_o    = we_q && (|sel_vec);
  assign mem_addr_o  = off_q;
  assign mem_wdata_o = wdata_q;
  assign ready_o     = done;
  assign err_o       = done && region_q == RG_RSVD;
  assign remap_o     = remap;

  always_comb begin
    rdata_o = '0;
    if (done) begin
      case (region_q)
        RG_SRAM:  rdata_o = sram_rdata_i;
        RG_FLASH: rdata_o = flash_rdata_i;
        RG_GPIO:  rdata_o = gpio_rdata_i;
        RG_PER:   rdata_o = per_rdata_i;
        RG_REMAP: rdata_o = {{(DATA_W-1){1'b0}}, remap};
        default:  rdata_o = '0;
      endcase
    end
  end

  // R6
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_vec));

  // R6
  err_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sel_vec == '0 && !mem_we_o));

  // R7
  fast_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_sel_o || flash_sel_o || gpio_sel_o) |-> ready_o);

  // R8
  slow_two_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_sel_o && !ready_o) |=> (per_sel_o && ready_o));
endmodule

// File: tb/boot_remap_decoder_bench.sv
module boot_remap_decoder_bench;
  localparam logic [31:0] SRAM_D  = 32'h5A5A_0001;
  localparam logic [31:0] FLASH_D = 32'hF1A5_0002;
  localparam logic [31:0] GPIO_D  = 32'h6910_0003;
  localparam logic [31:0] PER_D   = 32'hBEEF_0004;
  localparam logic [31:0] RMAP_A  = 32'hFFFF_0220;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic sram_sel, flash_sel, gpio_sel, per_sel, mem_we, ready, err, remap;
  logic [16:0] mem_addr;
  logic [31:0] mem_wdata, rdata;
  int checks = 0, errors = 0;
  bit rm_model = 1'b1;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_remap_decoder u_boot_remap_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .sram_rdata_i(SRAM_D), .flash_rdata_i(FLASH_D), .gpio_rdata_i(GPIO_D), .per_rdata_i(PER_D),
    .sram_sel_o(sram_sel), .flash_sel_o(flash_sel), .gpio_sel_o(gpio_sel), .per_sel_o(per_sel),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .ready_o(ready), .err_o(err), .rdata_o(rdata), .remap_o(remap)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // codes: 0 reserved, 1 sram, 2 flash, 3 gpio, 4 peripheral, 5 remap register
  task automatic model(input logic [31:0] a, input bit rm, output int code, output logic [16:0] off);
    code = 0; off = '0;
    if (a[31:17] == 0) begin
      if (rm) begin
        if (a[16:11] != 6'h3F) begin code = 2; off = a[16:0]; end
      end else begin code = 1; off = {4'b0, a[12:0]}; end
    end else if (a[31:13] == 19'h20) begin code = 1; off = {4'b0, a[12:0]}; end
    else if (a[31:17] == 15'h4) begin
      if (a[16:11] != 6'h3F) begin code = 2; off = a[16:0]; end
    end else if (a[31:2] == RMAP_A[31:2]) begin code = 5; off = {1'b0, a[15:0]}; end
    else if (a[31:8] == 24'hFFFFF4) begin code = 3; off = {9'b0, a[7:0]}; end
    else if (a[31:16] == 16'hFFFF) begin code = 4; off = {1'b0, a[15:0]}; end
  endtask

  task automatic acc(input bit w, input logic [31:0] a, input logic [31:0] wd,
                     output int lat, output logic [3:0] sel, output bit er,
                     output logic [31:0] rd, output logic [16:0] off, output bit mwe);
    @(negedge clk); req = 1'b1; we = w; addr = a; wdata = wd;
    @(negedge clk); req = 1'b0;
    lat = 1;
    while (!ready && lat < 6) begin @(negedge clk); lat++; end
    sel = {per_sel, gpio_sel, flash_sel, sram_sel};
    er = err; rd = rdata; off = mem_addr; mwe = mem_we;
  endtask

  task automatic run(input bit w, input logic [31:0] a, input logic [31:0] wd, input string rq);
    int code, lat, elat;
    logic [16:0] eoff, off;
    logic [3:0] sel, esel;
    logic [31:0] rd, erd;
    bit er, mwe;
    model(a, rm_model, code, eoff);
    acc(w, a, wd, lat, sel, er, rd, off, mwe);
    elat = (code >= 4) ? 2 : 1;
    case (code)
      1: begin esel = 4'b0001; erd = SRAM_D;  end
      2: begin esel = 4'b0010; erd = FLASH_D; end
      3: begin esel = 4'b0100; erd = GPIO_D;  end
      4: begin esel = 4'b1000; erd = PER_D;   end
      5: begin esel = 4'b0000; erd = {31'b0, rm_model}; end
      default: begin esel = 4'b0000; erd = '0; end
    endcase
    chk(lat == elat, {rq, " latency"}, lat, elat);
    chk(sel == esel, {rq, " select"}, {28'b0, sel}, {28'b0, esel});
    chk(er == (code == 0), {rq, " err"}, {31'b0, er}, {31'b0, code == 0});
    chk(mwe == (w && esel != 0), {rq, " write strobe"}, {31'b0, mwe}, {31'b0, w && esel != 0});
    if (!w) chk(rd == erd, {rq, " rdata"}, rd, erd);
    if (esel != 0) chk(off == eoff, {rq, " offset"}, {15'b0, off}, {15'b0, eoff});
    if (code == 5 && w) rm_model = wd[0];
    @(negedge clk);
    chk(remap == rm_model, {rq, " remap bit"}, {31'b0, remap}, {31'b0, rm_model});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ready, err, sram_sel, flash_sel, gpio_sel, per_sel} == 6'b0, "R1 outputs idle",
        {26'b0, ready, err, sram_sel, flash_sel, gpio_sel, per_sel}, '0);
    chk(remap == 1'b1, "R1 remap", {31'b0, remap}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(remap == 1'b1 && !ready, "R1 after release", {31'b0, remap}, 32'd1);

    run(0, 32'h0000_0100, '0, "R2 mirror flash");
    run(0, 32'h0001_F7FC, '0, "R2 mirror top user");
    run(0, 32'h0001_F800, '0, "R5 mirror boot page");
    run(0, 32'h0009_F7FC, '0, "R4 flash top user");
    run(0, 32'h0009_F800, '0, "R5 boot page direct");
    run(1, 32'h0009_FFFC, 32'h1, "R5 boot page write");
    run(0, 32'h0004_1FFC, '0, "R4 sram top");
    run(1, 32'h0004_0010, 32'hCAFE, "R4 sram write");
    run(0, 32'h0004_2000, '0, "R6 hole above sram");
    run(1, 32'h0010_0000, 32'h55, "R6 hole write");
    run(0, 32'hFFFF_F404, '0, "R7 gpio");
    run(0, 32'hFFFF_0400, '0, "R8 peripheral");
    run(1, 32'hFFFF_F3FC, 32'h9, "R8 peripheral write");
    run(0, RMAP_A, '0, "R9 read remap");
    run(1, RMAP_A, 32'hFFFF_FFFE, "R9 clear remap");
    run(0, RMAP_A, '0, "R9 upper bits zero");
    run(0, 32'h0000_2004, '0, "R3 sram wrap");
    run(0, 32'h0001_F800, '0, "R3 sram at mirror top");

    // R10: held request across a remap write completing
    @(negedge clk); req = 1'b1; we = 1'b1; addr = RMAP_A; wdata = 32'h1;
    @(negedge clk); we = 1'b0; addr = 32'h0000_1000;
    chk(!ready && !flash_sel && !sram_sel, "R10 in flight", {31'b0, ready}, '0);
    @(negedge clk);
    chk(ready && !err, "R10 remap write done", {31'b0, ready}, 32'd1);
    @(negedge clk);
    chk(!ready && !sram_sel && !flash_sel, "R10 held req not taken at completion",
        {30'b0, sram_sel, flash_sel}, '0);
    chk(remap == 1'b1, "R10 remap updated", {31'b0, remap}, 32'd1);
    @(negedge clk); req = 1'b0;
    chk(ready && flash_sel && !sram_sel, "R10 next access uses new mapping",
        {29'b0, ready, sram_sel, flash_sel}, 32'b101);
    chk(mem_addr == 17'h1000 && rdata == FLASH_D, "R10 next access data", rdata, FLASH_D);
    rm_model = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, wd;
      bit w;
      w  = ($urandom % 4) == 0;
      wd = $urandom;
      case ($urandom % 8)
        0: a = {15'b0, 17'($urandom)};
        1: a = 32'h0004_0000 | 32'($urandom % 32'h2000);
        2: a = 32'h0008_0000 | 32'($urandom % 32'h2_0000);
        3: a = 32'hFFFF_F400 | 32'($urandom % 32'h100);
        4: a = 32'hFFFF_0000 | 32'($urandom % 32'h1_0000);
        5: begin a = RMAP_A; w = ($urandom % 2) == 0; end
        6: a = $urandom;
        default: a = 32'h0009_F800 | 32'($urandom % 32'h800);
      endcase
      run(w, a, wd, "R2-mix random");
    end
    finish_run();
  end
endmodule